// File: doc/BRIEF.md
# Z80 Read Wait-State Generator

This block connects the read side of a Z80-style CPU bus to a memory port whose read data comes back after a variable number of command-clock cycles. The CPU control strobes arrive without any timing relationship to the command clock. The block synchronises them, recognises the start of an opcode fetch or an ordinary memory read, and issues one read request carrying the CPU address. It then counts command-clock cycles while it waits for the response.

Each kind of read has its own grace count, set at build time. If the response arrives before that count runs out, as it does on a fast cache hit, WAIT is never pulled low and the CPU finishes with no extra wait state. If the response is late, WAIT is held low until the response arrives. Once data is back, the byte is driven onto the CPU data bus until the CPU releases RD.

The request side uses a valid/ready handshake. `mem_req_valid` rises with `mem_req_addr` and both stay stable until a cycle in which `mem_req_ready` is high. That cycle completes the transfer. The response side has no back-pressure: the block always takes `mem_rsp_valid` and `mem_rsp_data` in the cycle they are presented. The memory must present exactly one response per accepted request, either in the acceptance cycle or later.

Top module: `z80_read_wait_gen`

## Requirements
- R1: While reset is high, and in the first cycle after it, `cpu_wait_n` is 1, `mem_req_valid` is 0 and `cpu_dout_en` is 0.
- R2: The strobes pass through two flip-flops. A read whose strobes go low just after edge E0 raises `mem_req_valid` in the cycle after the third edge. The request carries the CPU address and holds valid and address unchanged until `mem_req_ready` is 1.
- R3: A read with `cpu_m1_n`, `cpu_mreq_n` and `cpu_rd_n` all 0 is an opcode fetch and uses grace count GRACE_FETCH (0 to 7). Count the cycles after the request is raised, with the first one as cycle 0. If the response comes in cycle k and k > GRACE_FETCH, WAIT is low from cycle GRACE_FETCH through cycle k, which is k − GRACE_FETCH + 1 cycles.
- R4: A read with `cpu_mreq_n` and `cpu_rd_n` at 0 and `cpu_m1_n` at 1 is a memory read and follows the same rule with the separate count GRACE_READ.
- R5: If the response comes in cycle k ≤ grace, WAIT stays 1 for the whole read.
- R6: With a grace count of 0, WAIT goes low in cycle 0 unless the response is present in that same cycle.
- R7: Once WAIT is low, it returns to 1 in the cycle after the one in which `mem_rsp_valid` is 1.
- R8: From the cycle after the response until RD has been seen released through the synchroniser, `cpu_dout_en` is 1 and `cpu_dout` holds the returned byte. WAIT is never low while `cpu_dout_en` is 1.
- R9: If RD is released before the response arrives, the late response is consumed, no data is driven, and the next read works normally.
- R10: MREQ low with RD high (a write) raises no request and no WAIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock of the memory port |
| rst | input | 1 | Synchronous reset, active high |
| cpu_m1_n | input | 1 | CPU M1 strobe, active low, asynchronous |
| cpu_mreq_n | input | 1 | CPU memory request strobe, active low, asynchronous |
| cpu_rd_n | input | 1 | CPU read strobe, active low, asynchronous |
| cpu_addr | input | ADDR_W | CPU address bus |
| cpu_wait_n | output | 1 | WAIT to the CPU, active low |
| cpu_dout | output | DATA_W | Byte driven to the CPU data bus |
| cpu_dout_en | output | 1 | Output enable for `cpu_dout` |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | ADDR_W | Read request address |
| mem_rsp_valid | input | 1 | Read data ready, a one-cycle pulse |
| mem_rsp_data | input | DATA_W | Read data |

## Verification
Two events can fall in the same cycle: the grace count reaching its limit and the response arriving. A response exactly in cycle k = grace must leave WAIT high, while a response one cycle later gives two low cycles. The bench creates both cases by setting the responder latency and the request-ready delay so that k lands exactly on, and just past, the grace count of each read kind, including the zero-grace case where the response comes in the acceptance cycle. A cycle-by-cycle reference model judges WAIT on every clock. Each read's total count of low WAIT cycles is also compared with k − grace + 1.

// File: rtl/z80rw_pkg.sv
package z80rw_pkg;

  // Phases of one CPU read as seen from the command clock.
  typedef enum logic [1:0] {
    RS_IDLE  = 2'd0,  // no read in progress
    RS_PEND  = 2'd1,  // request out, grace count running
    RS_DRIVE = 2'd2,  // data returned, driving CPU bus
    RS_FLUSH = 2'd3   // CPU gave up, swallowing the late response
  } rd_phase_t;

  localparam int GRACE_LIMIT = 7;
  localparam int GRACE_CW    = $clog2(GRACE_LIMIT + 2);

endpackage

// File: rtl/z80rw_sync.sv
module z80rw_sync #(
  parameter int          WIDTH   = 3,
  parameter logic [WIDTH-1:0] IDLE_VAL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  // Two flops per strobe bit.
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic stage1, stage2;
    always_ff @(posedge clk) begin
      if (rst) begin
        stage1 <= IDLE_VAL[b];
        stage2 <= IDLE_VAL[b];
      end else begin
        stage1 <= async_in[b];
        stage2 <= stage1;
      end
    end
    assign sync_out[b] = stage2;
  end

endmodule

// File: rtl/z80rw_cycle_detect.sv
module z80rw_cycle_detect (
  input  logic clk,
  input  logic rst,
  input  logic m1_n_s,
  input  logic mreq_n_s,
  input  logic rd_n_s,
  output logic rd_active,
  output logic rd_start,
  output logic rd_is_fetch
);

  logic active_q;

  assign rd_active   = !mreq_n_s && !rd_n_s;
  assign rd_start    = rd_active && !active_q;
  assign rd_is_fetch = !m1_n_s;

  always_ff @(posedge clk) begin
    if (rst) active_q <= 1'b0;
    else     active_q <= rd_active;
  end

endmodule

// File: rtl/z80rw_grace_timer.sv
module z80rw_grace_timer
  import z80rw_pkg::*;
#(
  parameter int GRACE_FETCH = 3,
  parameter int GRACE_READ  = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic load_fetch,
  input  logic run,
  output logic at_limit,
  output logic past_limit
);

  localparam logic [GRACE_CW-1:0] LIM_F = GRACE_CW'(GRACE_FETCH);
  localparam logic [GRACE_CW-1:0] LIM_R = GRACE_CW'(GRACE_READ);

  logic [GRACE_CW-1:0] count_q;
  logic [GRACE_CW-1:0] limit_q;

  // Saturates one step past the limit: enough to tell "already stalled".
  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      limit_q <= '0;
    end else if (load) begin
      count_q <= '0;
      limit_q <= load_fetch ? LIM_F : LIM_R;
    end else if (run && count_q <= limit_q) begin
      count_q <= count_q + 1'b1;
    end
  end

  assign at_limit   = (count_q == limit_q);
  assign past_limit = (count_q >  limit_q);

endmodule

// File: rtl/z80_read_wait_gen.sv
module z80_read_wait_gen
  import z80rw_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int GRACE_FETCH = 3,
  parameter int GRACE_READ  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_m1_n,
  input  logic              cpu_mreq_n,
  input  logic              cpu_rd_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              cpu_wait_n,
  output logic [DATA_W-1:0] cpu_dout,
  output logic              cpu_dout_en,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data
);

  localparam int STROBES = 3;

  logic [STROBES-1:0] strobe_s;
  logic rd_active, rd_start, rd_is_fetch;
  logic at_limit, past_limit;
  rd_phase_t phase_q;
  logic [DATA_W-1:0] byte_q;
  logic req_q;
  logic [ADDR_W-1:0] addr_q;
  logic req_done;
  logic stall;

  z80rw_sync #(.WIDTH(STROBES), .IDLE_VAL('1)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in ({cpu_m1_n, cpu_mreq_n, cpu_rd_n}),
    .sync_out (strobe_s)
  );

  z80rw_cycle_detect u_detect (
    .clk         (clk),
    .rst         (rst),
    .m1_n_s      (strobe_s[2]),
    .mreq_n_s    (strobe_s[1]),
    .rd_n_s      (strobe_s[0]),
    .rd_active   (rd_active),
    .rd_start    (rd_start),
    .rd_is_fetch (rd_is_fetch)
  );

  z80rw_grace_timer #(
    .GRACE_FETCH (GRACE_FETCH),
    .GRACE_READ  (GRACE_READ)
  ) u_timer (
    .clk        (clk),
    .rst        (rst),
    .load       (phase_q == RS_IDLE && rd_start),
    .load_fetch (rd_is_fetch),
    .run        (phase_q == RS_PEND),
    .at_limit   (at_limit),
    .past_limit (past_limit)
  );

  assign req_done = req_q && mem_req_ready;

  // A response landing exactly on the expiry cycle suppresses the stall;
  // once stalled, the response cycle itself still shows WAIT low.
  assign stall = (phase_q == RS_PEND) &&
                 (past_limit || (at_limit && !mem_rsp_valid));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= RS_IDLE;
      req_q   <= 1'b0;
      addr_q  <= '0;
      byte_q  <= '0;
    end else begin
      unique case (phase_q)
        RS_IDLE: begin
          if (rd_start) begin
            phase_q <= RS_PEND;
            req_q   <= 1'b1;
            addr_q  <= cpu_addr;
          end
        end
        RS_PEND: begin
          if (req_done) req_q <= 1'b0;
          if (mem_rsp_valid) begin
            byte_q  <= mem_rsp_data;
            phase_q <= rd_active ? RS_DRIVE : RS_IDLE;
          end else if (!rd_active) begin
            phase_q <= RS_FLUSH;
          end
        end
        RS_DRIVE: begin
          if (!rd_active) phase_q <= RS_IDLE;
        end
        RS_FLUSH: begin
          if (req_done) req_q <= 1'b0;
          if (mem_rsp_valid) phase_q <= RS_IDLE;
        end
        default: phase_q <= RS_IDLE;
      endcase
    end
  end

  assign cpu_wait_n    = !stall;
  assign cpu_dout_en   = (phase_q == RS_DRIVE);
  assign cpu_dout      = byte_q;
  assign mem_req_valid = req_q;
  assign mem_req_addr  = addr_q;

endmodule

// File: rtl/z80rw_checker.sv
module z80rw_checker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_wait_n,
  input logic [DATA_W-1:0] cpu_dout,
  input logic              cpu_dout_en,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              mem_rsp_valid
);

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cpu_wait_n && !mem_req_valid && !cpu_dout_en));

  a_r2_request_held: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  a_r7_release_after_data: assert property (@(posedge clk) disable iff (rst)
    (!cpu_wait_n && mem_rsp_valid) |=> cpu_wait_n);

  a_r8_no_wait_while_driving: assert property (@(posedge clk) disable iff (rst)
    cpu_dout_en |-> cpu_wait_n);

  a_r8_byte_steady: assert property (@(posedge clk) disable iff (rst)
    cpu_dout_en |=> (!cpu_dout_en || $stable(cpu_dout)));

endmodule

bind z80_read_wait_gen z80rw_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_checker (
  .clk           (clk),
  .rst           (rst),
  .cpu_wait_n    (cpu_wait_n),
  .cpu_dout      (cpu_dout),
  .cpu_dout_en   (cpu_dout_en),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_rsp_valid (mem_rsp_valid)
);

// File: tb/test_z80_read_wait_gen.sv
module test_z80_read_wait_gen;

  localparam int AW = 16;
  localparam int DW = 8;
  localparam int GF = 3;
  localparam int GR = 0;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic          rst = 1'b1;
  logic          cpu_m1_n = 1'b1, cpu_mreq_n = 1'b1, cpu_rd_n = 1'b1;
  logic [AW-1:0] cpu_addr = '0;
  logic          cpu_wait_n, cpu_dout_en, mem_req_valid;
  logic [DW-1:0] cpu_dout;
  logic          mem_req_ready = 1'b0;
  logic [AW-1:0] mem_req_addr;
  logic          mem_rsp_valid = 1'b0;
  logic [DW-1:0] mem_rsp_data = '0;

  z80_read_wait_gen #(.ADDR_W(AW), .DATA_W(DW), .GRACE_FETCH(GF), .GRACE_READ(GR))
  i_z80_read_wait_gen (
    .clk(clk), .rst(rst),
    .cpu_m1_n(cpu_m1_n), .cpu_mreq_n(cpu_mreq_n), .cpu_rd_n(cpu_rd_n),
    .cpu_addr(cpu_addr), .cpu_wait_n(cpu_wait_n),
    .cpu_dout(cpu_dout), .cpu_dout_en(cpu_dout_en),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data)
  );

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  // Reference model state.
  bit [2:0] m_s1 = 3'b111, m_s2 = 3'b111;  // {m1, mreq, rd}
  bit m_prev = 0;
  int m_st = 0, m_cnt = 0, m_lim = 0;     // 0 idle, 1 pending, 2 drive, 3 flush
  bit m_req = 0;
  logic [AW-1:0] m_addr = '0;
  logic [DW-1:0] m_byte = '0;

  // Responder state.
  bit pend = 0;
  int lat_left = 0, cfg_lat = 0, rdy_left = 0;
  logic [DW-1:0] rsp_byte = '0;

  // Per-transaction observations.
  int waits_seen = 0, req_cycles = 0, txn_cyc = 0, first_req = -1;
  bit doe_seen = 0;
  logic [DW-1:0] dout_seen = '0;

  function automatic logic [DW-1:0] mem_of(logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit exp_wait;
    exp_wait = (m_st == 1) && ((m_cnt > m_lim) || (m_cnt == m_lim && !mem_rsp_valid));
    // Wait timing covers R3 R4 R5 R6 R7 cycle by cycle.
    chk(cpu_wait_n == !exp_wait, "R3", "wait_n per cycle", int'(cpu_wait_n), int'(!exp_wait));
    chk(mem_req_valid == m_req, "R2", "req_valid per cycle", int'(mem_req_valid), int'(m_req));
    if (m_req) chk(mem_req_addr == m_addr, "R2", "req_addr", int'(mem_req_addr), int'(m_addr));
    chk(cpu_dout_en == (m_st == 2), "R8", "dout_en per cycle", int'(cpu_dout_en), int'(m_st == 2));
    if (m_st == 2) chk(cpu_dout == m_byte, "R8", "dout per cycle", int'(cpu_dout), int'(m_byte));
    txn_cyc++;
    if (!cpu_wait_n) waits_seen++;
    if (mem_req_valid) begin
      req_cycles++;
      if (first_req < 0) first_req = txn_cyc;
    end
    if (cpu_dout_en) begin doe_seen = 1; dout_seen = cpu_dout; end
  endtask

  task automatic model_update();
    bit act;
    bit rdy;
    rdy = m_req && mem_req_ready;
    if (rst) begin
      m_s1 = 3'b111; m_s2 = 3'b111; m_prev = 0; m_st = 0; m_cnt = 0; m_lim = 0;
      m_req = 0; m_addr = '0; m_byte = '0;
      return;
    end
    act = !m_s2[1] && !m_s2[0];
    case (m_st)
      0: if (act && !m_prev) begin
           m_st = 1; m_cnt = 0; m_lim = !m_s2[2] ? GF : GR; m_req = 1; m_addr = cpu_addr;
         end
      1: begin
           if (rdy) m_req = 0;
           if (mem_rsp_valid) begin m_byte = mem_rsp_data; m_st = act ? 2 : 0; end
           else if (!act) m_st = 3;
           if (m_cnt <= m_lim) m_cnt++;
         end
      2: if (!act) m_st = 0;
      default: begin
           if (rdy) m_req = 0;
           if (mem_rsp_valid) m_st = 0;
         end
    endcase
    m_prev = act;
    m_s2 = m_s1;
    m_s1 = {cpu_m1_n, cpu_mreq_n, cpu_rd_n};
  endtask

  task automatic responder_update();
    if (rst) begin pend = 0; return; end
    if (pend) begin
      if (lat_left == 0) pend = 0; else lat_left--;
    end
    if (mem_req_valid && mem_req_ready) begin
      if (cfg_lat > 0) begin
        pend = 1; lat_left = cfg_lat - 1; rsp_byte = mem_of(mem_req_addr);
      end
    end else if (mem_req_valid && rdy_left > 0) rdy_left--;
  endtask

  task automatic cycle();
    bit fast;
    @(negedge clk);
    mem_req_ready = mem_req_valid && (rdy_left == 0);
    fast = mem_req_valid && mem_req_ready && (cfg_lat == 0);
    mem_rsp_valid = (pend && lat_left == 0) || fast;
    mem_rsp_data  = fast ? mem_of(mem_req_addr) : rsp_byte;
    #1;
    if (!rst) compare();
    @(posedge clk);
    model_update();
    responder_update();
    #1;
  endtask

  task automatic clear_obs();
    waits_seen = 0; req_cycles = 0; txn_cyc = 0; first_req = -1; doe_seen = 0;
  endtask

  task automatic release_bus();
    cpu_m1_n = 1; cpu_mreq_n = 1; cpu_rd_n = 1;
    repeat (5) cycle();
    chk(!cpu_dout_en, "R8", "dout_en after RD release", int'(cpu_dout_en), 0);
  endtask

  // k = rdyd + lat is the pending-cycle index in which the response arrives.
  task automatic do_read(bit fetch, logic [AW-1:0] a, int lat, int rdyd, string tag);
    int g, k, expw;
    g = fetch ? GF : GR;
    k = rdyd + lat;
    expw = (k > g) ? (k - g + 1) : 0;
    clear_obs();
    cfg_lat = lat; rdy_left = rdyd;
    cpu_m1_n = !fetch; cpu_mreq_n = 0; cpu_rd_n = 0; cpu_addr = a;
    for (int i = 0; i < 60 && !doe_seen; i++) cycle();
    chk(first_req == 4, "R2", "request first cycle", first_req, 4);
    chk(waits_seen == expw, tag, "wait cycles in read", waits_seen, expw);
    chk(dout_seen == mem_of(a), "R8", "byte returned", int'(dout_seen), int'(mem_of(a)));
    release_bus();
  endtask

  initial begin
    repeat (3) cycle();
    chk(cpu_wait_n && !mem_req_valid && !cpu_dout_en, "R1", "outputs in reset",
        int'({cpu_wait_n, mem_req_valid, cpu_dout_en}), 4);
    rst = 0;
    cycle();
    chk(cpu_wait_n && !mem_req_valid && !cpu_dout_en, "R1", "outputs after reset",
        int'({cpu_wait_n, mem_req_valid, cpu_dout_en}), 4);

    do_read(1, 16'h1234, 0, 0, "R5");  // fetch, response in cycle 0
    do_read(1, 16'h2001, 3, 0, "R5");  // fetch, response exactly at grace
    do_read(1, 16'h3002, 4, 0, "R3");  // fetch, one late: two WAIT cycles
    do_read(1, 16'h4003, 3, 2, "R3");  // fetch with request back-pressure (R2)
    do_read(0, 16'h5004, 0, 0, "R6");  // read, grace 0, response same cycle
    do_read(0, 16'h6005, 1, 0, "R6");  // read, grace 0, one late
    do_read(0, 16'h7006, 6, 0, "R4");  // read, long latency (R7 release)
    do_read(0, 16'h8007, 2, 3, "R4");  // read with back-pressure

    // R9: RD released before the response arrives.
    clear_obs();
    cfg_lat = 12; rdy_left = 0;
    cpu_m1_n = 1; cpu_mreq_n = 0; cpu_rd_n = 0; cpu_addr = 16'h9008;
    repeat (6) cycle();
    cpu_mreq_n = 1; cpu_rd_n = 1;
    repeat (20) cycle();
    chk(!doe_seen, "R9", "no data driven on abandoned read", int'(doe_seen), 0);
    chk(cpu_wait_n, "R9", "wait released after flush", int'(cpu_wait_n), 1);
    do_read(1, 16'hA009, 1, 0, "R9");

    // R10: write cycle raises nothing.
    clear_obs();
    cpu_m1_n = 1; cpu_mreq_n = 0; cpu_rd_n = 1; cpu_addr = 16'hB00A;
    repeat (10) cycle();
    chk(req_cycles == 0, "R10", "request cycles during write", req_cycles, 0);
    chk(waits_seen == 0, "R10", "wait cycles during write", waits_seen, 0);
    cpu_mreq_n = 1;
    repeat (3) cycle();

    // Back-to-back fetch then read, R7 release on each.
    do_read(1, 16'hC00B, 5, 1, "R7");
    do_read(0, 16'hD00C, 3, 0, "R7");

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog run did not complete actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule